// File: doc/BRIEF.md
# Multiply, Multiply-Accumulate and Divide Execute Unit

This block is the long-latency arithmetic lane of an execute stage. A one-cycle `start` pulse hands it an operation code, up to three operands and two destination register indices. It returns each result on a registered writeback port made of a valid strobe, a data word and the destination index. A multiply or multiply-accumulate produces one writeback. An unsigned divide produces two ordered writebacks: the quotient first, then the remainder one cycle later.

The multiplier has two forms, chosen at build time by the parameter `SLOW_MUL`. The fast form computes the product in one registered step. The slow form retires two multiplier bits per cycle, so that 32-bit operands take 16 cycles. The divider is a restoring, bit-serial circuit. Its total occupancy is fixed by `DIV_CYCLES` and does not depend on the operand values. `busy` tells the issue logic when a new `start` would be dropped.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy` and `res_valid` are 0.
- R2: With `SLOW_MUL`=0, a start with `op`=2'b00 (multiply) gives `res_valid`=1 in the cycle after the start cycle. `res_data` holds the low XLEN bits of `src_a*src_b`, `res_dst` equals `dst_q`, and `busy` stays 0.
- R3: With `SLOW_MUL`=1, the multiply result and `dst_q` appear 16 cycles after the start cycle. `busy` is 1 in cycles 1 to 15.
- R4: `op`=2'b01 (multiply-accumulate) returns the low XLEN bits of `src_a*src_b+src_c` to `dst_q`. It appears 2 cycles after the start with `SLOW_MUL`=0 and 17 cycles after with `SLOW_MUL`=1.
- R5: `op`=2'b10 (unsigned divide) writes `src_a/src_b` to `dst_q` in cycle 36 after the start. It then writes `src_a%src_b` to `dst_r` in cycle 37.
- R6: A divide by zero gives an all-ones quotient and a remainder equal to `src_a`, with the same timing as R5.
- R7: `busy` is 1 from the cycle after an accepted start until the cycle before the last writeback of that operation. A start in the cycle of the last writeback is accepted.
- R8: A start while `busy` is 1 is ignored. A start with `op`=2'b11 is ignored.
- R9: `res_valid` is 1 for exactly one cycle per writeback and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a new operation |
| op | input | 2 | 00 multiply, 01 multiply-accumulate, 10 unsigned divide, 11 reserved |
| src_a | input | XLEN | Multiplicand or dividend |
| src_b | input | XLEN | Multiplier or divisor |
| src_c | input | XLEN | Addend for multiply-accumulate |
| dst_q | input | DSTW | Destination of the product or quotient |
| dst_r | input | DSTW | Destination of the remainder |
| busy | output | 1 | Unit occupied; a start is dropped |
| res_valid | output | 1 | Writeback strobe |
| res_data | output | XLEN | Writeback data |
| res_dst | output | DSTW | Writeback destination index |

## Verification
Counting the start cycle as cycle 0, each result is due in a fixed cycle. The fast build delivers multiply in cycle 1 and multiply-accumulate in cycle 2. The slow build delivers them in cycles 16 and 17. Both builds deliver the quotient in cycle 36 and the remainder in cycle 37. The bench runs one fast and one slow instance side by side. For every cycle from 1 to the latest due cycle, it samples both instances at the falling edge and compares `res_valid`, `busy`, data and destination with a schedule it derives from the operation. A valid strobe in any other cycle is an error. The next operation is started in the very cycle the previous one delivers its last result. This exercises back-to-back acceptance, and the cycle count stays aligned across the whole run.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MAC  = 2'b01,
    OP_DIV  = 2'b10,
    OP_NONE = 2'b11
  } md_op_e;

  // Cycle (counted from the start cycle) of the final writeback.
  function automatic int last_due(input md_op_e o, input bit slow,
                                  input int xlen, input int div_cycles);
    case (o)
      OP_MUL:  last_due = slow ? xlen / 2 : 1;
      OP_MAC:  last_due = slow ? xlen / 2 + 1 : 2;
      OP_DIV:  last_due = div_cycles + 1;
      default: last_due = 0;
    endcase
  endfunction

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int XLEN = 32,
  parameter int DSTW = 5,
  parameter bit SLOW = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            is_mac,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] c,
  input  logic [DSTW-1:0] dst,
  output logic            out_v,
  output logic [XLEN-1:0] out_d,
  output logic [DSTW-1:0] out_dst
);

  localparam int STEPS = XLEN / 2;
  localparam int SW    = $clog2(STEPS + 1);

  logic [XLEN-1:0] prod_q;
  logic [XLEN-1:0] addend_q;
  logic [DSTW-1:0] dst_hold;
  logic            pend;

  generate
    if (!SLOW) begin : g_fast
      always_ff @(posedge clk) begin
        if (rst) begin
          out_v    <= 1'b0;
          out_d    <= '0;
          out_dst  <= '0;
          prod_q   <= '0;
          addend_q <= '0;
          dst_hold <= '0;
          pend     <= 1'b0;
        end else begin
          out_v <= 1'b0;
          if (pend) begin
            out_d   <= prod_q + addend_q;
            out_dst <= dst_hold;
            out_v   <= 1'b1;
            pend    <= 1'b0;
          end
          if (go) begin
            if (is_mac) begin
              prod_q   <= a * b;
              addend_q <= c;
              dst_hold <= dst;
              pend     <= 1'b1;
            end else begin
              out_d   <= a * b;
              out_dst <= dst;
              out_v   <= 1'b1;
            end
          end
        end
      end
    end else begin : g_slow
      logic [XLEN-1:0] acc;
      logic [XLEN-1:0] a_sh;
      logic [XLEN-1:0] b_sh;
      logic [SW-1:0]   step;
      logic            run;
      logic            mac_q;
      logic [XLEN-1:0] pp_now;

      // Partial product of one radix-4 digit.
      function automatic logic [XLEN-1:0] digit_pp(input logic [XLEN-1:0] x,
                                                   input logic [1:0] d);
        case (d)
          2'd0:    digit_pp = '0;
          2'd1:    digit_pp = x;
          2'd2:    digit_pp = x << 1;
          default: digit_pp = x + (x << 1);
        endcase
      endfunction

      assign pp_now = digit_pp(a_sh, b_sh[1:0]);

      always_ff @(posedge clk) begin
        if (rst) begin
          out_v    <= 1'b0;
          out_d    <= '0;
          out_dst  <= '0;
          prod_q   <= '0;
          addend_q <= '0;
          dst_hold <= '0;
          pend     <= 1'b0;
          acc      <= '0;
          a_sh     <= '0;
          b_sh     <= '0;
          step     <= '0;
          run      <= 1'b0;
          mac_q    <= 1'b0;
        end else begin
          out_v <= 1'b0;
          if (pend) begin
            out_d   <= prod_q + addend_q;
            out_dst <= dst_hold;
            out_v   <= 1'b1;
            pend    <= 1'b0;
          end
          if (run) begin
            if (step == SW'(STEPS - 1)) begin
              run <= 1'b0;
              if (mac_q) begin
                prod_q <= acc + pp_now;
                pend   <= 1'b1;
              end else begin
                out_d   <= acc + pp_now;
                out_dst <= dst_hold;
                out_v   <= 1'b1;
              end
            end else begin
              acc  <= acc + pp_now;
              a_sh <= a_sh << 2;
              b_sh <= b_sh >> 2;
              step <= step + 1'b1;
            end
          end
          if (go) begin
            acc      <= digit_pp(a, b[1:0]);
            a_sh     <= a << 2;
            b_sh     <= b >> 2;
            step     <= SW'(1);
            run      <= 1'b1;
            mac_q    <= is_mac;
            addend_q <= c;
            dst_hold <= dst;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int XLEN       = 32,
  parameter int DSTW       = 5,
  parameter int DIV_CYCLES = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [DSTW-1:0] dq,
  input  logic [DSTW-1:0] dr,
  output logic            out_v,
  output logic            out_last,
  output logic [XLEN-1:0] out_d,
  output logic [DSTW-1:0] out_dst
);

  localparam int CW = $clog2(DIV_CYCLES + 1);

  logic [XLEN-1:0] rem;
  logic [XLEN-1:0] quo;
  logic [XLEN-1:0] dv;
  logic [DSTW-1:0] dq_h, dr_h;
  logic [CW-1:0]   cnt;
  logic            run;
  logic [XLEN:0]   trial;
  logic [XLEN:0]   diff;
  logic            fits;

  assign trial = {rem, quo[XLEN-1]};
  assign diff  = trial - {1'b0, dv};
  assign fits  = (trial >= {1'b0, dv});

  always_ff @(posedge clk) begin
    if (rst) begin
      rem      <= '0;
      quo      <= '0;
      dv       <= '0;
      dq_h     <= '0;
      dr_h     <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      out_v    <= 1'b0;
      out_last <= 1'b0;
      out_d    <= '0;
      out_dst  <= '0;
    end else begin
      out_v    <= 1'b0;
      out_last <= 1'b0;
      if (run) begin
        cnt <= cnt + 1'b1;
        if (cnt <= CW'(XLEN)) begin
          rem <= fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
          quo <= {quo[XLEN-2:0], fits};
        end
        if (cnt == CW'(DIV_CYCLES - 1)) begin
          out_d   <= quo;
          out_dst <= dq_h;
          out_v   <= 1'b1;
        end
        if (cnt == CW'(DIV_CYCLES)) begin
          out_d    <= rem;
          out_dst  <= dr_h;
          out_v    <= 1'b1;
          out_last <= 1'b1;
          run      <= 1'b0;
        end
      end
      if (go) begin
        rem  <= '0;
        quo  <= a;
        dv   <= b;
        dq_h <= dq;
        dr_h <= dr;
        cnt  <= CW'(1);
        run  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int XLEN       = 32,
  parameter int DSTW       = 5,
  parameter bit SLOW_MUL   = 1'b0,
  parameter int DIV_CYCLES = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] src_c,
  input  logic [DSTW-1:0] dst_q,
  input  logic [DSTW-1:0] dst_r,
  output logic            busy,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic [DSTW-1:0] res_dst
);
  import muldiv_pkg::*;

  localparam int LW = $clog2(DIV_CYCLES + 2);

  md_op_e          op_e;
  logic            accept;
  logic [LW-1:0]   due;
  logic [LW-1:0]   left;
  logic            mul_v, div_v, div_last;
  logic [XLEN-1:0] mul_d, div_d;
  logic [DSTW-1:0] mul_dst, div_dst;

  assign op_e   = md_op_e'(op);
  assign accept = start && !busy && (op_e != OP_NONE);
  assign due    = LW'(last_due(op_e, SLOW_MUL, XLEN, DIV_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (accept) begin
      busy <= (due > LW'(1));
      left <= due - 1'b1;
    end else if (busy) begin
      left <= left - 1'b1;
      if (left == LW'(1)) busy <= 1'b0;
    end
  end

  muldiv_mul #(.XLEN(XLEN), .DSTW(DSTW), .SLOW(SLOW_MUL)) u_mul (
    .clk(clk), .rst(rst),
    .go(accept && (op_e == OP_MUL || op_e == OP_MAC)),
    .is_mac(op_e == OP_MAC),
    .a(src_a), .b(src_b), .c(src_c), .dst(dst_q),
    .out_v(mul_v), .out_d(mul_d), .out_dst(mul_dst)
  );

  muldiv_div #(.XLEN(XLEN), .DSTW(DSTW), .DIV_CYCLES(DIV_CYCLES)) u_div (
    .clk(clk), .rst(rst),
    .go(accept && op_e == OP_DIV),
    .a(src_a), .b(src_b), .dq(dst_q), .dr(dst_r),
    .out_v(div_v), .out_last(div_last), .out_d(div_d), .out_dst(div_dst)
  );

  assign res_valid = mul_v | div_v;
  assign res_data  = div_v ? div_d : mul_d;
  assign res_dst   = div_v ? div_dst : mul_dst;

endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
  parameter bit SLOW_MUL = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] op,
  input logic       busy,
  input logic       res_valid,
  input logic       mul_v,
  input logic       div_v,
  input logic       div_last
);

  generate
    if (!SLOW_MUL) begin : g_fast
      p_fast_mul_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 2'b00) |=> (res_valid && !busy));
    end else begin : g_slow
      p_slow_mul_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 2'b00) |=> (busy && !res_valid));
    end
  endgenerate

  p_div_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b10) |=> busy);

  p_rem_after_quo_r5: assert property (@(posedge clk) disable iff (rst)
    (div_v && div_last) |-> $past(div_v && !div_last));

  p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> res_valid);

  p_rsvd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b11) |=> !busy);

  p_one_source_r9: assert property (@(posedge clk) disable iff (rst)
    !(mul_v && div_v));

endmodule

bind muldiv_unit muldiv_chk #(.SLOW_MUL(SLOW_MUL)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .busy(busy),
  .res_valid(res_valid), .mul_v(mul_v), .div_v(div_v), .div_last(div_last)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic [4:0]  dst_q = '0, dst_r = '0;

  logic        bz_f, v_f, bz_s, v_s;
  logic [31:0] d_f, d_s;
  logic [4:0]  t_f, t_s;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_unit uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .src_a(src_a),
    .src_b(src_b), .src_c(src_c), .dst_q(dst_q), .dst_r(dst_r),
    .busy(bz_f), .res_valid(v_f), .res_data(d_f), .res_dst(t_f));

  muldiv_unit #(.SLOW_MUL(1'b1)) uut_slow (
    .clk(clk), .rst(rst), .start(start), .op(op), .src_a(src_a),
    .src_b(src_b), .src_c(src_c), .dst_q(dst_q), .dst_r(dst_r),
    .busy(bz_s), .res_valid(v_s), .res_data(d_s), .res_dst(t_s));

  function automatic int due1(input logic [1:0] o, input bit slow);
    case (o)
      2'b00: due1 = slow ? 16 : 1;
      2'b01: due1 = slow ? 17 : 2;
      2'b10: due1 = 36;
      default: due1 = 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] o, input bit slow,
                                   input logic [31:0] b);
    case (o)
      2'b00: tag_of = slow ? "R3" : "R2";
      2'b01: tag_of = "R4";
      2'b10: tag_of = (b == 0) ? "R6" : "R5";
      default: tag_of = "R8";
    endcase
  endfunction

  task automatic check_cycle(input bit slow, input int cyc, input int l1, input int l2,
                             input logic [31:0] e1, input logic [31:0] e2,
                             input logic [4:0] q, input logic [4:0] r, input string tg);
    logic v, bz;
    logic [31:0] d;
    logic [4:0] t;
    int last;
    bit ev, eb;
    v  = slow ? v_s : v_f;
    bz = slow ? bz_s : bz_f;
    d  = slow ? d_s : d_f;
    t  = slow ? t_s : t_f;
    last = (l2 > 0) ? l2 : l1;
    ev = (cyc == l1) || (cyc == l2);
    eb = (cyc < last);
    checks++;
    if (v !== ev) begin
      errors++;
      $display("FAIL %s/R9 slow=%0d cyc %0d: valid=%b expected %b", tg, slow, cyc, v, ev);
    end else if (bz !== eb) begin
      errors++;
      $display("FAIL R7 (%s) slow=%0d cyc %0d: busy=%b expected %b", tg, slow, cyc, bz, eb);
    end else if (ev && cyc == l1 && (d !== e1 || t !== q)) begin
      errors++;
      $display("FAIL %s slow=%0d cyc %0d: data=%h dst=%0d expected %h dst=%0d",
               tg, slow, cyc, d, t, e1, q);
    end else if (ev && cyc == l2 && (d !== e2 || t !== r)) begin
      errors++;
      $display("FAIL %s slow=%0d cyc %0d: rem=%h dst=%0d expected %h dst=%0d",
               tg, slow, cyc, d, t, e2, r);
    end
  endtask

  // Starts an operation in the current cycle (called at a falling edge);
  // inj>=2 drives an extra multiply start in that cycle (R8).
  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic [4:0] q, input logic [4:0] r,
                        input int inj);
    logic [31:0] e1, e2;
    int lf, ls, l2, lmax;
    string tf, ts;
    lf = due1(o, 1'b0);
    ls = due1(o, 1'b1);
    l2 = (o == 2'b10) ? 37 : 0;
    case (o)
      2'b00: begin e1 = a * b; e2 = '0; end
      2'b01: begin e1 = a * b + c; e2 = '0; end
      2'b10: begin e1 = (b == 0) ? 32'hFFFF_FFFF : a / b; e2 = (b == 0) ? a : a % b; end
      default: begin e1 = '0; e2 = '0; end
    endcase
    lmax = (l2 > 0) ? l2 : ((ls > 0) ? ls : 3);
    tf = tag_of(o, 1'b0, b);
    ts = tag_of(o, 1'b1, b);
    if (inj > 0) begin tf = "R8"; ts = "R8"; end
    start = 1'b1; op = o; src_a = a; src_b = b; src_c = c; dst_q = q; dst_r = r;
    for (int cyc = 1; cyc <= lmax; cyc++) begin
      @(negedge clk);
      if (cyc == 1) start = 1'b0;
      check_cycle(1'b0, cyc, lf, l2, e1, e2, q, r, tf);
      check_cycle(1'b1, cyc, ls, l2, e1, e2, q, r, ts);
      if (cyc == inj) begin
        start = 1'b1; op = 2'b00; src_a = 32'd3; src_b = 32'd5; dst_q = 5'd30;
      end else if (cyc == inj + 1) begin
        start = 1'b0;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected end before 100000 cycles");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] ra, rb, rc;
    logic [1:0]  ro;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (bz_f !== 1'b0 || v_f !== 1'b0 || bz_s !== 1'b0 || v_s !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: busy=%b%b valid=%b%b expected 0", bz_f, bz_s, v_f, v_s);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (bz_f !== 1'b0 || v_f !== 1'b0 || bz_s !== 1'b0 || v_s !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: busy=%b%b valid=%b%b expected 0", bz_f, bz_s, v_f, v_s);
    end

    // Directed corners
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 5'd1, 5'd0, 0);  // R2 R3
    run_op(2'b00, 32'd12345, 32'd0, 0, 5'd2, 5'd0, 0);
    run_op(2'b01, 32'h8000_0001, 32'd3, 32'hFFFF_FFF0, 5'd3, 5'd0, 0); // R4 wrap
    run_op(2'b10, 32'd100, 32'd7, 0, 5'd4, 5'd5, 0);                // R5
    run_op(2'b10, 32'hDEAD_BEEF, 32'd0, 0, 5'd6, 5'd7, 0);          // R6
    run_op(2'b10, 32'd3, 32'hFFFF_FFFF, 0, 5'd8, 5'd9, 0);          // R5 a<b
    run_op(2'b10, 32'hFFFF_FFFF, 32'd1, 0, 5'd10, 5'd11, 5);        // R8 start while busy
    run_op(2'b11, 32'd9, 32'd9, 0, 5'd12, 5'd13, 0);                // R8 reserved op
    run_op(2'b00, 32'd7, 32'd6, 0, 5'd14, 5'd0, 0);                 // R7 after idle

    // Constrained random mix; each op starts in the prior op's final cycle (R7)
    for (int i = 0; i < 40; i++) begin
      ro = 2'($urandom_range(0, 2));
      ra = $urandom;
      rb = ($urandom_range(0, 7) == 0) ? 32'd0 :
           (($urandom_range(0, 1) == 1) ? 32'($urandom_range(1, 1000)) : $urandom);
      rc = $urandom;
      run_op(ro, ra, rb, rc, 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule